// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block gives two independent ports of a 1024 x 8 shared byte memory a way to signal each other. The two highest addresses are set aside as mailboxes, one per direction. When the left port writes a byte to the top address, the right port's active-low interrupt goes low. When the right port writes to the address just below it, the left port's interrupt goes low. The receiving port reads its incoming mailbox with its output enable low, and that access clears its interrupt.

The mailbox bytes stay ordinary memory. Both ports can read and write them like any other location, so the message itself is whatever byte the sender left there. Each port has a hold input, active low. While a port's hold input is low, its writes are dropped, and so are the interrupts those writes would raise.

The memory is synchronous. Reads return registered data one cycle after the access. Arbitration between the ports is left to surrounding logic.

Top module: `mbx_dualport`

## Requirements
- R1: A port stores `wdata` at `addr` when `sel_n`=0, `we_n`=0 and `hold_n`=1 at a rising clock edge. A port with `sel_n`=0, `we_n`=1 and `oe_n`=0 at an edge presents the stored byte on `rdata` after that edge. `rdata` holds its value when the port is not reading.
- R2: A left-port write (as in R1) to address 0x3FF drives `r_irq_n` low from the next edge.
- R3: A right-port write (as in R1) to address 0x3FE drives `l_irq_n` low from the next edge.
- R4: A right-port access to 0x3FF with `sel_n`=0 and `oe_n`=0 returns `r_irq_n` high after the edge, whatever the level of `we_n`. A left-port access to 0x3FE under the same conditions does the same for `l_irq_n`.
- R5: The bytes at 0x3FE and 0x3FF are stored and read back exactly like any other address.
- R6: While a port's `hold_n` is 0, its writes change neither the memory nor the opposite port's interrupt.
- R7: After reset, both `l_irq_n` and `r_irq_n` are high.
- R8: If one cycle both sets and clears the same interrupt, the interrupt ends up asserted (low).
- R9: If one port writes an address and the other port reads the same address in the same cycle, the read returns the contents from before the write.
- R10: Accesses to addresses other than the two mailboxes never change either interrupt. Neither does a read of a port's own outgoing mailbox.
- R11: An access to the incoming mailbox with `oe_n`=1 does not clear the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left write strobe, active low (high selects read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hold_n | input | 1 | Left write inhibit, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right write strobe, active low (high selects read) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hold_n | input | 1 | Right write inhibit, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Two collisions can occur in one cycle:
- **Set and clear of one interrupt.** The sender writes a mailbox while the receiver reads the same mailbox with its output enable low. The bench drives both ports in one cycle, once with the interrupt idle and once with it already pending. It expects the interrupt to be low afterwards in both cases.
- **Write and read of one location.** The same paired access also makes one port write a location that the other port is reading. The bench expects the read to return the byte that was there before, and a later read to return the new byte.

Full address sweeps from each side confirm that no other address moves either interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded intent of one port for the current cycle
    typedef struct packed {
        logic wr;          // qualified write into storage
        logic rd;          // qualified read out of storage
        logic raise_peer;  // write hit the outgoing mailbox
        logic drop_own;    // enabled access hit the incoming mailbox
    } port_req_t;

    // Pending interrupt state, one bit per receiving port
    typedef struct packed {
        logic l_pend;
        logic r_pend;
    } flag_state_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int AW = 10,
    parameter logic [AW-1:0] OUT_BOX = '1,
    parameter logic [AW-1:0] IN_BOX  = '0
) (
    input  logic          sel_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          hold_n,
    input  logic [AW-1:0] addr,
    output port_req_t     req
);

    logic hit_out;
    logic hit_in;

    always_comb begin
        hit_out        = (addr == OUT_BOX);
        hit_in         = (addr == IN_BOX);
        req.wr         = !sel_n && !we_n && hold_n;
        req.rd         = !sel_n && we_n && !oe_n;
        req.raise_peer = req.wr && hit_out;
        // clear ignores the write strobe level
        req.drop_own   = !sel_n && !oe_n && hit_in;
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic          b_re,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] a_out;
        logic [DW-1:0] b_out;
    } rd_state_t;

    logic [DW-1:0] mem [DEPTH];
    rd_state_t     rd_d;
    rd_state_t     rd_q;

    // read-before-write: array value sampled before this edge's update
    always_comb begin
        rd_d = rd_q;
        if (a_re) rd_d.a_out = mem[a_addr];
        if (b_re) rd_d.b_out = mem[b_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // storage carries no reset; same-address collision resolves to port b
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    assign a_rdata = rd_q.a_out;
    assign b_rdata = rd_q.b_out;

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic l_irq_n,
    output logic r_irq_n
);

    flag_state_t st_d;
    flag_state_t st_q;

    always_comb begin
        st_d = st_q;
        // clear first so a simultaneous set overrides it
        if (clr_l) st_d.l_pend = 1'b0;
        if (set_l) st_d.l_pend = 1'b1;
        if (clr_r) st_d.r_pend = 1'b0;
        if (set_r) st_d.r_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_irq_n = ~st_q.l_pend;
    assign r_irq_n = ~st_q.r_pend;

    a_r8_set_wins_l: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_irq_n);
    a_r8_set_wins_r: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_irq_n);
    a_r4_clear_l: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_irq_n);
    a_r4_clear_r: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_irq_n);
    a_r10_quiet_l: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_l && !clr_l) |=> $stable(l_irq_n));
    a_r10_quiet_r: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !clr_r) |=> $stable(r_irq_n));

endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport
    import mbx_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel_n,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic          l_hold_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_irq_n,
    input  logic          r_sel_n,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic          r_hold_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_irq_n
);

    // top address carries left-to-right messages, the one below it the reverse
    localparam logic [AW-1:0] BOX_L2R = '1;
    localparam logic [AW-1:0] BOX_R2L = BOX_L2R - AW'(1);

    port_req_t l_req;
    port_req_t r_req;

    mbx_port_decode #(.AW(AW), .OUT_BOX(BOX_L2R), .IN_BOX(BOX_R2L)) u_dec_l (
        .sel_n (l_sel_n),
        .we_n  (l_we_n),
        .oe_n  (l_oe_n),
        .hold_n(l_hold_n),
        .addr  (l_addr),
        .req   (l_req)
    );

    mbx_port_decode #(.AW(AW), .OUT_BOX(BOX_R2L), .IN_BOX(BOX_L2R)) u_dec_r (
        .sel_n (r_sel_n),
        .we_n  (r_we_n),
        .oe_n  (r_oe_n),
        .hold_n(r_hold_n),
        .addr  (r_addr),
        .req   (r_req)
    );

    mbx_store #(.AW(AW), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_we   (l_req.wr),
        .a_re   (l_req.rd),
        .a_addr (l_addr),
        .a_wdata(l_wdata),
        .a_rdata(l_rdata),
        .b_we   (r_req.wr),
        .b_re   (r_req.rd),
        .b_addr (r_addr),
        .b_wdata(r_wdata),
        .b_rdata(r_rdata)
    );

    mbx_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_l  (r_req.raise_peer),
        .clr_l  (l_req.drop_own),
        .set_r  (l_req.raise_peer),
        .clr_r  (r_req.drop_own),
        .l_irq_n(l_irq_n),
        .r_irq_n(r_irq_n)
    );

    a_r6_hold_blocks_l: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_hold_n && r_irq_n) |=> r_irq_n);
    a_r6_hold_blocks_r: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_hold_n && l_irq_n) |=> l_irq_n);
    a_r2_only_left_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_irq_n) |-> $past(!l_sel_n && !l_we_n && l_hold_n && (l_addr == BOX_L2R)));
    a_r3_only_right_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_irq_n) |-> $past(!r_sel_n && !r_we_n && r_hold_n && (r_addr == BOX_R2L)));

endmodule

// File: tb/sim_mbx_dualport.sv
`timescale 1ns/100ps
module sim_mbx_dualport;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_hold_n = 1'b1;
    logic [9:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       l_irq_n;
    logic       r_sel_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_hold_n = 1'b1;
    logic [9:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;
    logic       r_irq_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    mbx_dualport u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_hold_n(l_hold_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_sel_n(r_sel_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_hold_n(r_hold_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    function automatic logic [7:0] pat_a(int a);
        return 8'((a * 37 + 11));
    endfunction

    function automatic logic [7:0] pat_b(int a);
        return 8'((a * 13) ^ 8'h5C ^ (a >> 3));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_sel_n = 1; l_we_n = 1; l_oe_n = 1; l_hold_n = 1;
        r_sel_n = 1; r_we_n = 1; r_oe_n = 1; r_hold_n = 1;
    endtask

    task automatic l_write(input logic [9:0] a, input logic [7:0] d, input bit hold);
        l_sel_n = 0; l_we_n = 0; l_addr = a; l_wdata = d; l_hold_n = ~hold;
        @(negedge clk);
        idle();
    endtask

    task automatic r_write(input logic [9:0] a, input logic [7:0] d, input bit hold);
        r_sel_n = 0; r_we_n = 0; r_addr = a; r_wdata = d; r_hold_n = ~hold;
        @(negedge clk);
        idle();
    endtask

    task automatic l_read(input logic [9:0] a, output logic [7:0] d);
        l_sel_n = 0; l_oe_n = 0; l_addr = a;
        @(negedge clk);
        d = l_rdata;
        idle();
    endtask

    task automatic r_read(input logic [9:0] a, output logic [7:0] d);
        r_sel_n = 0; r_oe_n = 0; r_addr = a;
        @(negedge clk);
        d = r_rdata;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk({l_irq_n, r_irq_n} == 2'b11, "R7 reset flags", {l_irq_n, r_irq_n}, 3);

        // R10 + R1: left fills every non-mailbox address, flags stay idle
        for (int a = 0; a < 1022; a++) begin
            l_write(10'(a), pat_a(a), 0);
            chk({l_irq_n, r_irq_n} == 2'b11, "R10 left sweep flags", {l_irq_n, r_irq_n}, 3);
        end
        for (int a = 0; a < 1022; a++) begin
            r_read(10'(a), rd);
            chk(rd == pat_a(a), "R1 right reads left data", rd, pat_a(a));
        end
        // R10: right fills, left reads back
        for (int a = 0; a < 1022; a++) begin
            r_write(10'(a), pat_b(a), 0);
            chk({l_irq_n, r_irq_n} == 2'b11, "R10 right sweep flags", {l_irq_n, r_irq_n}, 3);
        end
        for (int a = 0; a < 1022; a++) begin
            l_read(10'(a), rd);
            chk(rd == pat_b(a), "R1 left reads right data", rd, pat_b(a));
        end
        chk({l_irq_n, r_irq_n} == 2'b11, "R10 flags after reads", {l_irq_n, r_irq_n}, 3);

        // R2: left posts a message to the right
        l_write(10'h3FF, 8'h5A, 0);
        chk(r_irq_n == 1'b0, "R2 right irq set", r_irq_n, 0);
        chk(l_irq_n == 1'b1, "R2 left irq untouched", l_irq_n, 1);

        // R11: access without output enable does not clear
        r_sel_n = 0; r_we_n = 1; r_oe_n = 1; r_addr = 10'h3FF;
        @(negedge clk);
        idle();
        chk(r_irq_n == 1'b0, "R11 no clear without oe", r_irq_n, 0);

        // R10: right reading its own outgoing box leaves both flags
        r_read(10'h3FE, rd);
        chk({l_irq_n, r_irq_n} == 2'b10, "R10 read of own outbox", {l_irq_n, r_irq_n}, 2);

        // R4 + R5: right reads its mailbox, gets the byte, irq clears
        r_read(10'h3FF, rd);
        chk(rd == 8'h5A, "R5 right mailbox byte", rd, 8'h5A);
        chk(r_irq_n == 1'b1, "R4 right irq cleared", r_irq_n, 1);

        // R3: right posts a message to the left
        r_write(10'h3FE, 8'hC3, 0);
        chk(l_irq_n == 1'b0, "R3 left irq set", l_irq_n, 0);
        l_read(10'h3FE, rd);
        chk(rd == 8'hC3, "R5 left mailbox byte", rd, 8'hC3);
        chk(l_irq_n == 1'b1, "R4 left irq cleared by read", l_irq_n, 1);

        // R4: clear with write strobe low; R5: that write stores normally
        r_write(10'h3FE, 8'h21, 0);
        chk(l_irq_n == 1'b0, "R3 left irq set again", l_irq_n, 0);
        l_sel_n = 0; l_we_n = 0; l_oe_n = 0; l_addr = 10'h3FE; l_wdata = 8'h11;
        @(negedge clk);
        idle();
        chk(l_irq_n == 1'b1, "R4 clear ignores we_n", l_irq_n, 1);
        r_read(10'h3FE, rd);
        chk(rd == 8'h11, "R5 mailbox write stored", rd, 8'h11);

        // R6: held writes change neither storage nor the peer interrupt
        l_write(10'h3FF, 8'h77, 1);
        chk(r_irq_n == 1'b1, "R6 held left mailbox write", r_irq_n, 1);
        r_read(10'h3FF, rd);
        chk(rd == 8'h5A, "R6 held write left mailbox intact", rd, 8'h5A);
        l_write(10'h010, 8'hAB, 1);
        l_read(10'h010, rd);
        chk(rd == pat_b(16), "R6 held write plain address", rd, pat_b(16));
        r_write(10'h3FE, 8'h99, 1);
        chk(l_irq_n == 1'b1, "R6 held right mailbox write", l_irq_n, 1);

        // R8 + R9: set and clear in one cycle, flag idle beforehand
        l_sel_n = 0; l_we_n = 0; l_addr = 10'h3FF; l_wdata = 8'h42;
        r_sel_n = 0; r_oe_n = 0; r_addr = 10'h3FF;
        @(negedge clk);
        idle();
        chk(r_irq_n == 1'b0, "R8 set wins from idle", r_irq_n, 0);
        chk(r_rdata == 8'h5A, "R9 read sees old byte", r_rdata, 8'h5A);
        // R8: again with flag already pending
        l_sel_n = 0; l_we_n = 0; l_addr = 10'h3FF; l_wdata = 8'h43;
        r_sel_n = 0; r_oe_n = 0; r_addr = 10'h3FF;
        @(negedge clk);
        idle();
        chk(r_irq_n == 1'b0, "R8 set wins while pending", r_irq_n, 0);
        chk(r_rdata == 8'h42, "R9 read sees previous write", r_rdata, 8'h42);
        r_read(10'h3FF, rd);
        chk(rd == 8'h43, "R9 later read sees new byte", rd, 8'h43);
        chk(r_irq_n == 1'b1, "R4 lone clear", r_irq_n, 1);

        // R9: plain address collision
        l_sel_n = 0; l_we_n = 0; l_addr = 10'h100; l_wdata = 8'hEE;
        r_sel_n = 0; r_oe_n = 0; r_addr = 10'h100;
        @(negedge clk);
        idle();
        chk(r_rdata == pat_b(256), "R9 plain collision old data", r_rdata, pat_b(256));
        r_read(10'h100, rd);
        chk(rd == 8'hEE, "R9 plain collision new data", rd, 8'hEE);

        // R1: rdata holds while idle
        @(negedge clk);
        chk(r_rdata == 8'hEE, "R1 rdata holds when idle", r_rdata, 8'hEE);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule